// File: doc/BRIEF.md
# Interrupt Mask and Routing Controller

This block gathers thirty-two level-sensitive interrupt request lines and steers each one onto one of fifteen interrupt output lines. Every input first passes through a two-flop synchronizer. The synchronized levels can be read back as a status word. A per-input enable bit in a mask word decides whether an active input counts as pending. A 4-bit route code per input chooses the output line that a pending input drives. Code 0 leaves the input unconnected.

Software reaches the state through a plain word-wide register port with separate read and write strobes. There is an enable word, a status word and four routing words. Route codes are packed eight to a word. The routing words are filled from the top input group down, so the first routing word holds inputs 24 to 31. Each output line is the registered OR of every pending input whose code selects it. An output therefore follows its sources for as long as they stay high.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every mask bit and every route code is 0, all outputs are low, and a read of any register returns 0 while the inputs stay low.
- R2: The mask word at byte offset 0x00 is fully readable and writable. Bit n enables input n when 1 and blocks it when 0.
- R3: The four routing words at offsets 0x08, 0x0C, 0x10 and 0x14 are fully readable and writable. The code for input n sits in routing word 3 - n/8, at offset 0x08 + 4*(3 - n/8), in bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R4: A read of offset 0x04 returns the synchronized input levels, with bit n giving input n. A write to 0x04 changes neither any register nor any output.
- R5: Output bit k-1 of irq_out stands for route code k (k = 1..15). It is high when at least one input has its mask bit at 1, a synchronized level of 1 and code k.
- R6: An input whose route code is 0 drives no output, whatever its mask bit and level.
- R7: An input whose mask bit is 0 drives no output, whatever its route code and level.
- R8: Outputs are level-sensitive. An output stays high while any input that selects it remains pending, and it falls only after the last such input is removed.
- R9: A read of any offset other than the six defined ones (including misaligned offsets) returns 0. A write to such an offset has no effect.
- R10: Output timing is fixed: an input change shows on irq_out after exactly three rising clock edges. Read data appears on bus_rdata one edge after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs, asynchronous to clk |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 15 | Output lines; bit k-1 carries route code k |

## Verification
The hardest behaviour to reach from the ports is the reversed placement of the route fields. An error there only shows when a single input is active and its code differs from the codes of its neighbours. To reach it, the bench fills all four routing words with a pattern that gives each input its own computed code, including some zero codes. It then raises each of the thirty-two inputs on its own and compares the output word with a model that decodes the field position arithmetically. A second sweep steps one input through all sixteen codes, and a third walks the mask. The three-edge output lag is checked one edge early and exactly on time.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    // Byte offsets of the register windows; the route window holds one
    // word per group of eight inputs, highest group first.
    localparam logic [7:0] OFF_MASK       = 8'h00;
    localparam logic [7:0] OFF_STATUS     = 8'h04;
    localparam logic [7:0] OFF_ROUTE_BASE = 8'h08;
    localparam int unsigned WORD_BYTES    = 4;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = async_in;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_route_pkg::*;
#(
    parameter int unsigned N_IN   = 32,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [N_IN-1:0]          wr_data,
    input  logic                     rd_en,
    input  logic [N_IN-1:0]          status,
    output logic [N_IN-1:0]          mask,
    output logic [N_IN*CODE_W-1:0]   codes,
    output logic [N_IN-1:0]          rd_data
);
    localparam int unsigned FIELDS     = N_IN / CODE_W;
    localparam int unsigned ROUTE_REGS = (N_IN * CODE_W) / N_IN;
    localparam int unsigned IDX_W      = (ROUTE_REGS > 1) ? $clog2(ROUTE_REGS) : 1;

    typedef struct packed {
        logic [N_IN-1:0]                  mask;
        logic [ROUTE_REGS-1:0][N_IN-1:0]  route;
        logic [N_IN-1:0]                  rd_data;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic              hit_mask, hit_status, hit_route;
    logic [ADDR_W-1:0] route_rel;
    logic [IDX_W-1:0]  route_idx;

    // Address decode
    always_comb begin
        hit_mask   = (addr == ADDR_W'(OFF_MASK));
        hit_status = (addr == ADDR_W'(OFF_STATUS));
        route_rel  = addr - ADDR_W'(OFF_ROUTE_BASE);
        hit_route  = (addr >= ADDR_W'(OFF_ROUTE_BASE))
                   && (route_rel < ADDR_W'(ROUTE_REGS * WORD_BYTES))
                   && (route_rel[1:0] == 2'b00);
        route_idx  = route_rel[IDX_W+1:2];
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (hit_mask)  st_d.mask = wr_data;
            if (hit_route) st_d.route[route_idx] = wr_data;
        end
        if (rd_en) begin
            st_d.rd_data = '0;
            if (hit_mask)   st_d.rd_data = st_q.mask;
            if (hit_status) st_d.rd_data = status;
            if (hit_route)  st_d.rd_data = st_q.route[route_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Unpack the reversed word order into one code per input
    generate
        for (genvar n = 0; n < N_IN; n++) begin : g_code
            assign codes[n*CODE_W +: CODE_W] =
                st_q.route[ROUTE_REGS-1-(n/FIELDS)][CODE_W*(n%FIELDS) +: CODE_W];
        end
    endgenerate

    assign mask    = st_q.mask;
    assign rd_data = st_q.rd_data;

    // The mask only moves on a write aimed at its offset
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && hit_mask) |-> $stable(st_q.mask));

    // Routing words only move on a write inside the route window
    assert_route_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && hit_route) |-> $stable(st_q.route));

    // Reads outside the map return zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !(hit_mask || hit_status || hit_route)) |-> (rd_data == '0));

    // Read data holds between reads
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
    parameter int unsigned N_IN   = 32,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned N_OUT  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         status,
    input  logic [N_IN-1:0]         mask,
    input  logic [N_IN*CODE_W-1:0]  codes,
    output logic [N_OUT-1:0]        irq_out
);
    typedef struct packed {
        logic [N_OUT-1:0] lines;
    } mg_state_t;

    mg_state_t st_d, st_q;

    logic [N_IN-1:0]             pending;
    logic [N_OUT-1:0][N_IN-1:0]  sel;

    assign pending = status & mask;

    // Decoder matrix: sel[k][n] marks input n as carrying code k+1
    generate
        for (genvar k = 0; k < N_OUT; k++) begin : g_line
            for (genvar n = 0; n < N_IN; n++) begin : g_src
                assign sel[k][n] = (codes[n*CODE_W +: CODE_W] == CODE_W'(k + 1));
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N_OUT; k++) begin
            st_d.lines[k] = |(pending & sel[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.lines;

    // With every code zero, no line can rise
    assert_code_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(codes == '0) |-> (irq_out == '0));

    // A high line needs some pending source one cycle earlier
    assert_line_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> $past(pending != '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned N_IN        = 32,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           irq_in,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic [N_IN-1:0]           bus_wdata,
    input  logic                      bus_rd,
    output logic [N_IN-1:0]           bus_rdata,
    output logic [(2**CODE_W)-2:0]    irq_out
);
    localparam int unsigned N_OUT = (2 ** CODE_W) - 1;

    logic [N_IN-1:0]        level_sync;
    logic [N_IN-1:0]        mask_w;
    logic [N_IN*CODE_W-1:0] codes_w;

    irq_sync #(
        .W      (N_IN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (level_sync)
    );

    irq_regfile #(
        .N_IN   (N_IN),
        .CODE_W (CODE_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .rd_en   (bus_rd),
        .status  (level_sync),
        .mask    (mask_w),
        .codes   (codes_w),
        .rd_data (bus_rdata)
    );

    irq_route_merge #(
        .N_IN   (N_IN),
        .CODE_W (CODE_W),
        .N_OUT  (N_OUT)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (level_sync),
        .mask    (mask_w),
        .codes   (codes_w),
        .irq_out (irq_out)
    );

    // Leaving reset, the outputs are quiet
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_out == '0));

    // A fully closed mask keeps every line low on the following edge
    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> $past(mask_w != '0));
endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic [14:0] irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] mask_m;
    logic [31:0] route_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [14:0] exp_out(input logic [31:0] lv);
        logic [14:0] r = '0;
        for (int n = 0; n < 32; n++) begin
            logic [3:0] code = 4'((route_m[3 - n/8] >> (4 * (n % 8))) & 32'hF);
            if (lv[n] && mask_m[n] && code != 4'd0) r[code - 1] = 1'b1;
        end
        return r;
    endfunction

    task automatic set_mask(input logic [31:0] m);
        bus_write(8'h00, m);
        mask_m = m;
    endtask

    task automatic set_route(input int r, input logic [31:0] v);
        bus_write(8'(8'h08 + 4 * r), v);
        route_m[r] = v;
    endtask

    initial begin : main
        logic [31:0] rd;
        rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wr = 1'b0;
        bus_wdata = '0; bus_rd = 1'b0;
        mask_m = '0;
        for (int r = 0; r < 4; r++) route_m[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 outputs", 32'(irq_out), 32'h0);
        for (int a = 0; a < 6; a++) begin
            bus_read(8'(4 * a), rd);
            chk("R1 register", rd, 32'h0);
        end

        // R2: mask read/write
        set_mask(32'hA5C3_0F96);
        bus_read(8'h00, rd);
        chk("R2 mask readback", rd, 32'hA5C3_0F96);
        set_mask(32'hFFFF_FFFF);
        bus_read(8'h00, rd);
        chk("R2 mask all ones", rd, 32'hFFFF_FFFF);

        // R3: routing words read/write, distinct per word
        for (int r = 0; r < 4; r++) set_route(r, 32'h1234_5678 ^ (32'h1111_1111 * r));
        for (int r = 0; r < 4; r++) begin
            bus_read(8'(8'h08 + 4 * r), rd);
            chk("R3 route readback", rd, route_m[r]);
        end

        // R9: unmapped and misaligned offsets
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h09, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'h0);
        bus_write(8'h02, 32'h0);
        bus_read(8'h00, rd);
        chk("R9 mask untouched", rd, mask_m);
        for (int r = 0; r < 4; r++) begin
            bus_read(8'(8'h08 + 4 * r), rd);
            chk("R9 route untouched", rd, route_m[r]);
        end
        bus_read(8'h18, rd);  chk("R9 read 0x18", rd, 32'h0);
        bus_read(8'h0A, rd);  chk("R9 read 0x0A", rd, 32'h0);
        bus_read(8'h80, rd);  chk("R9 read 0x80", rd, 32'h0);

        // R3/R5/R6: per-input sweep with computed codes (some are zero)
        for (int r = 0; r < 4; r++) begin
            logic [31:0] v = '0;
            for (int f = 0; f < 8; f++) v |= 32'(((r * 8 + f) * 7 + 3) % 16) << (4 * f);
            set_route(r, v);
        end
        set_mask(32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            @(negedge clk);
            irq_in = 32'h1 << n;
            settle();
            chk("R3 R5 R6 per-input route", 32'(irq_out), 32'(exp_out(irq_in)));
            irq_in = '0;
            settle();
        end

        // R5/R6: one input through every code (input 13 -> word 2, bits 23:20)
        for (int r = 0; r < 4; r++) set_route(r, 32'h0);
        @(negedge clk); irq_in = 32'h1 << 13;
        for (int c = 0; c < 16; c++) begin
            set_route(2, 32'(c) << 20);
            settle();
            chk(c == 0 ? "R6 code zero" : "R5 code sweep", 32'(irq_out), 32'(exp_out(irq_in)));
        end

        // R7: mask walk with all inputs high and all codes nonzero
        for (int r = 0; r < 4; r++) begin
            logic [31:0] v = '0;
            for (int f = 0; f < 8; f++) v |= 32'(((r * 8 + f) % 15) + 1) << (4 * f);
            set_route(r, v);
        end
        @(negedge clk); irq_in = 32'hFFFF_FFFF;
        set_mask(32'h0);
        settle();
        chk("R7 mask closed", 32'(irq_out), 32'h0);
        for (int n = 0; n < 32; n += 3) begin
            set_mask(32'h1 << n);
            settle();
            chk("R7 single mask bit", 32'(irq_out), 32'(exp_out(irq_in)));
        end
        set_mask(32'h0F0F_F0F0);
        settle();
        chk("R7 mixed mask", 32'(irq_out), 32'(exp_out(irq_in)));

        // R8: three sources on code 9, removed one at a time
        @(negedge clk); irq_in = '0;
        for (int r = 0; r < 4; r++) set_route(r, 32'h0);
        set_route(3, 32'h0000_0090);   // input 1
        set_route(1, 32'h0900_0000);   // input 22
        set_route(0, 32'h9000_0000);   // input 31
        set_mask(32'hFFFF_FFFF);
        @(negedge clk); irq_in = (32'h1 << 1) | (32'h1 << 22) | (32'h1 << 31);
        settle();
        chk("R8 three sources", 32'(irq_out), 32'h100);
        irq_in[22] = 1'b0; settle();
        chk("R8 two sources", 32'(irq_out), 32'h100);
        irq_in[1] = 1'b0; settle();
        chk("R8 one source", 32'(irq_out), 32'h100);
        irq_in[31] = 1'b0; settle();
        chk("R8 none", 32'(irq_out), 32'h0);

        // R10: exact three-edge lag, rising and falling
        @(negedge clk); irq_in[31] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 not yet high", 32'(irq_out), 32'h0);
        @(negedge clk);
        chk("R10 high on third edge", 32'(irq_out), 32'h100);
        irq_in[31] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 still high", 32'(irq_out), 32'h100);
        @(negedge clk);
        chk("R10 low on third edge", 32'(irq_out), 32'h0);

        // R4: status readback and ignored writes
        @(negedge clk); irq_in = 32'hC3A5_5A3C;
        settle();
        bus_read(8'h04, rd);
        chk("R4 status levels", rd, 32'hC3A5_5A3C);
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, rd);
        chk("R4 status write ignored", rd, 32'hC3A5_5A3C);
        bus_read(8'h00, rd);
        chk("R4 mask unaffected", rd, mask_m);
        chk("R4 outputs unaffected", 32'(irq_out), 32'(exp_out(irq_in)));
        // R10: read data holds after the strobe
        repeat (3) @(negedge clk);
        chk("R10 rdata hold", bus_rdata, mask_m);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule